// File: doc/BRIEF.md
# Synchronous Serial Audio Port

This block is the word-level core of a synchronous serial port that sits between a DSP core and an audio routing fabric. For each transmit word strobe it sends one word from its transmit holding register, and for each receive word strobe it captures one word into its receive holding register. The DSP configures and services the port through four word-wide registers: two control registers, a status register and a shared data address (write loads the transmit word, read returns the received word).

Word length is programmable to 8, 12, 16 or 24 bits. The transmit path right-aligns the top bits of the 24-bit holding word, and the receive path left-aligns the incoming word into 24 bits. Either path can optionally reverse the bit order over the word length. Frame-sync events arrive separately for each direction. In network mode they set or clear a per-direction frame flag and release a direction that was just enabled; in normal mode any frame-sync event only sets the flag. The frame-rate divider field is decoded and presented for an external clock generator.

Top module: `sser_link`

## Requirements
- R1: After reset the status register reads 0x000001 (only the transmit-empty flag, bit 0, set), the transmit line is 0, both control registers read 0, and both directions are waiting for a frame.
- R2: Control register A (address 0) bits [1:0] select the word length: 0 = 8, 1 = 12, 2 = 16, 3 = 24 bits. On a transmit strobe the line carries the holding word shifted right by (24 - length) and masked to the length, from the next cycle on.
- R3: On a receive strobe the input word is shifted left by (24 - length) and truncated to 24 bits before it is stored; reading address 3 returns the stored word.
- R4: When control register B (address 1) bit 1 is set, the aligned word on either path is bit-reversed: bit i moves to bit (length - 1 - i) and bits at or above the length are 0.
- R5: A 0-to-1 write of transmit-enable (control B bit 4) puts transmit into the waiting state; a transmit strobe while transmit-enable is 0 or while waiting drives 0 on the line.
- R6: A 0-to-1 write of receive-enable (control B bit 5) puts receive into the waiting state; a receive strobe while receive-enable is 0 or while waiting stores 0.
- R7: A transmit strobe sets transmit-empty (status bit 0); writing address 3 or writing the status address (2) clears it, and such a write wins over a strobe in the same cycle.
- R8: A receive strobe sets receive-full (status bit 1); a read of address 3 clears it, and a strobe in the same cycle wins.
- R9: With network mode (control B bit 3) set, a frame-sync event with value 1 sets that direction's frame flag (status bit 2 transmit, bit 3 receive) and ends its waiting state; value 0 clears the flag.
- R10: With network mode clear, any frame-sync event sets the frame flag and leaves the waiting state unchanged.
- R11: Control A bits [6:2] hold the frame-rate field; the frame_div output equals that field plus one.
- R12: Control registers read back what was written (control A bits [6:0], control B bits [7:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 2 | Register address: 0 ctrl A, 1 ctrl B, 2 status, 3 data |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data for reg_addr (combinational) |
| tx_strobe | input | 1 | Transmit word event |
| rx_strobe | input | 1 | Receive word event |
| tx_fs_ev | input | 1 | Transmit frame-sync event |
| tx_fs_val | input | 1 | Transmit frame-sync value |
| rx_fs_ev | input | 1 | Receive frame-sync event |
| rx_fs_val | input | 1 | Receive frame-sync value |
| rx_line | input | 24 | Received word from the routing fabric |
| tx_line | output | 24 | Transmitted word to the routing fabric |
| frame_div | output | 6 | Decoded frame-rate divider |
| flag_tde | output | 1 | Transmit-empty flag |
| flag_rdf | output | 1 | Receive-full flag |
| flag_tfs | output | 1 | Transmit frame flag |
| flag_rfs | output | 1 | Receive frame flag |

## Verification
One 24-bit pattern, 0x123456, with an asymmetric bit layout is sent through every word length with and without reversal, so a wrong shift amount, a wrong mask or a reversal over the wrong span each give a distinct result. The receive path uses patterns whose bits straddle the truncation boundary, so a missing truncation or a reversal applied before alignment shows up. Directed sequences cover strobes before any frame sync, re-enabling a direction, frame syncs of both values in both modes, and the flag set/clear rules.

// File: rtl/sser_pkg.sv
package sser_pkg;

    localparam int WORD_W = 24;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int DIVF_W = 5;

    localparam logic [1:0] A_CTLA = 2'd0;
    localparam logic [1:0] A_CTLB = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

    typedef enum logic [1:0] {WL_8 = 2'd0, WL_12 = 2'd1, WL_16 = 2'd2, WL_24 = 2'd3} wlen_e;

    typedef struct packed {
        logic rx_irq_en;
        logic tx_irq_en;
        logic rx_en;
        logic tx_en;
        logic net;
        logic sync;
        logic rev;
        logic clk_out;
    } ctlb_t;

    typedef struct packed {
        logic flag;
        logic waiting;
    } frame_st_t;

    typedef struct packed {
        wlen_e              wl;
        logic [DIVF_W-1:0]  divf;
        ctlb_t              ctlb;
        logic [WORD_W-1:0]  tx_data;
        logic [WORD_W-1:0]  rx_data;
        logic [WORD_W-1:0]  tx_out;
        logic               tde;
        logic               rdf;
    } core_st_t;

    function automatic int unsigned wl_bits(wlen_e c);
        case (c)
            WL_8:    return 8;
            WL_12:   return 12;
            WL_16:   return 16;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/sser_align.sv
module sser_align
    import sser_pkg::*;
#(
    parameter int DATA_W  = WORD_W,
    parameter bit TO_LINE = 1'b1
) (
    input  logic [DATA_W-1:0] din,
    input  wlen_e             wl,
    input  logic              rev,
    output logic [DATA_W-1:0] dout
);
    localparam int IW = $clog2(DATA_W);

    int unsigned       len;
    int unsigned       sh;
    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] flipped;

    always_comb begin
        len = wl_bits(wl);
        sh  = DATA_W - len;
    end

    generate
        if (TO_LINE) begin : g_right
            always_comb aligned = (din >> sh) & ~({DATA_W{1'b1}} << len);
        end else begin : g_left
            always_comb aligned = din << sh;
        end
    endgenerate

    always_comb begin
        flipped = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(len)) begin
                flipped[IW'(i)] = aligned[IW'(int'(len) - 1 - i)];
            end
        end
        dout = rev ? flipped : aligned;
    end

endmodule

// File: rtl/sser_frame.sv
module sser_frame
    import sser_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fs_ev,
    input  logic fs_val,
    input  logic net,
    input  logic en_rise,
    output logic flag,
    output logic waiting
);
    frame_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fs_ev) begin
            if (net) begin
                st_d.flag = fs_val;
                if (fs_val) st_d.waiting = 1'b0;
            end else begin
                st_d.flag = 1'b1;
            end
        end
        if (en_rise) st_d.waiting = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flag: 1'b0, waiting: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag    = st_q.flag;
    assign waiting = st_q.waiting;

endmodule

// File: rtl/sser_link.sv
module sser_link
    import sser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              tx_strobe,
    input  logic              rx_strobe,
    input  logic              tx_fs_ev,
    input  logic              tx_fs_val,
    input  logic              rx_fs_ev,
    input  logic              rx_fs_val,
    input  logic [WORD_W-1:0] rx_line,
    output logic [WORD_W-1:0] tx_line,
    output logic [DIVF_W:0]   frame_div,
    output logic              flag_tde,
    output logic              flag_rdf,
    output logic              flag_tfs,
    output logic              flag_rfs
);
    localparam int CTLA_W = DIVF_W + 2;
    localparam int CTLB_W = $bits(ctlb_t);

    core_st_t          st_d, st_q;
    ctlb_t             ctlb_new;
    logic              wr_ctla, wr_ctlb, wr_stat, wr_data, rd_data;
    logic              tx_en_rise, rx_en_rise;
    logic              tx_wait, rx_wait;
    logic [WORD_W-1:0] tx_aligned, rx_aligned;

    always_comb begin
        wr_ctla    = reg_wr && (reg_addr == A_CTLA);
        wr_ctlb    = reg_wr && (reg_addr == A_CTLB);
        wr_stat    = reg_wr && (reg_addr == A_STAT);
        wr_data    = reg_wr && (reg_addr == A_DATA);
        rd_data    = reg_rd && (reg_addr == A_DATA);
        ctlb_new   = ctlb_t'(reg_wdata[CTLB_W-1:0]);
        tx_en_rise = wr_ctlb && !st_q.ctlb.tx_en && ctlb_new.tx_en;
        rx_en_rise = wr_ctlb && !st_q.ctlb.rx_en && ctlb_new.rx_en;
    end

    sser_align #(.DATA_W(WORD_W), .TO_LINE(1'b1)) u_tx_align (
        .din  (st_q.tx_data),
        .wl   (st_q.wl),
        .rev  (st_q.ctlb.rev),
        .dout (tx_aligned)
    );

    sser_align #(.DATA_W(WORD_W), .TO_LINE(1'b0)) u_rx_align (
        .din  (rx_line),
        .wl   (st_q.wl),
        .rev  (st_q.ctlb.rev),
        .dout (rx_aligned)
    );

    sser_frame u_tx_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .fs_ev   (tx_fs_ev),
        .fs_val  (tx_fs_val),
        .net     (st_q.ctlb.net),
        .en_rise (tx_en_rise),
        .flag    (flag_tfs),
        .waiting (tx_wait)
    );

    sser_frame u_rx_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .fs_ev   (rx_fs_ev),
        .fs_val  (rx_fs_val),
        .net     (st_q.ctlb.net),
        .en_rise (rx_en_rise),
        .flag    (flag_rfs),
        .waiting (rx_wait)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctla) begin
            st_d.wl   = wlen_e'(reg_wdata[1:0]);
            st_d.divf = reg_wdata[CTLA_W-1:2];
        end
        if (wr_ctlb) st_d.ctlb = ctlb_new;

        if (tx_strobe) begin
            st_d.tx_out = (st_q.ctlb.tx_en && !tx_wait) ? tx_aligned : '0;
            st_d.tde    = 1'b1;
        end
        if (wr_data) begin
            st_d.tx_data = reg_wdata;
            st_d.tde     = 1'b0;
        end
        if (wr_stat) st_d.tde = 1'b0;

        if (rd_data) st_d.rdf = 1'b0;
        if (rx_strobe) begin
            st_d.rx_data = (st_q.ctlb.rx_en && !rx_wait) ? rx_aligned : '0;
            st_d.rdf     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.tde <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTLA:  reg_rdata[CTLA_W-1:0] = {st_q.divf, st_q.wl};
            A_CTLB:  reg_rdata[CTLB_W-1:0] = st_q.ctlb;
            A_STAT:  reg_rdata[3:0] = {flag_rfs, flag_tfs, st_q.rdf, st_q.tde};
            default: reg_rdata = st_q.rx_data;
        endcase
    end

    assign tx_line   = st_q.tx_out;
    assign frame_div = {1'b0, st_q.divf} + 1'b1;
    assign flag_tde  = st_q.tde;
    assign flag_rdf  = st_q.rdf;

endmodule

// File: rtl/sser_link_chk.sv
module sser_link_chk
    import sser_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic              tx_strobe,
    input logic              rx_strobe,
    input logic              tx_fs_ev,
    input logic              tx_fs_val,
    input logic              tx_en,
    input logic              net,
    input logic [WORD_W-1:0] tx_line,
    input logic              flag_tde,
    input logic              flag_rdf,
    input logic              flag_tfs
);
    logic tde_clear_wr;
    assign tde_clear_wr = reg_wr && ((reg_addr == A_DATA) || (reg_addr == A_STAT));

    // R7
    tde_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe && !tde_clear_wr |=> flag_tde);

    // R7
    tde_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tde_clear_wr |=> !flag_tde);

    // R8
    rdf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> flag_rdf);

    // R8
    rdf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && (reg_addr == A_DATA) && !rx_strobe |=> !flag_rdf);

    // R5
    tx_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe && !tx_en |=> tx_line == '0);

    // R9
    net_fs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        net && tx_fs_ev && !tx_fs_val |=> !flag_tfs);

    // R10
    norm_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !net && tx_fs_ev |=> flag_tfs);

endmodule

bind sser_link sser_link_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .tx_strobe (tx_strobe),
    .rx_strobe (rx_strobe),
    .tx_fs_ev  (tx_fs_ev),
    .tx_fs_val (tx_fs_val),
    .tx_en     (st_q.ctlb.tx_en),
    .net       (st_q.ctlb.net),
    .tx_line   (tx_line),
    .flag_tde  (flag_tde),
    .flag_rdf  (flag_rdf),
    .flag_tfs  (flag_tfs)
);

// File: tb/sser_link_tb.sv
module sser_link_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    // {is_tx, wl code, reverse, input word, expected word}
    localparam logic [51:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 1'b0, 24'h123456, 24'h000012},
        {1'b1, 2'd0, 1'b1, 24'h123456, 24'h000048},
        {1'b1, 2'd1, 1'b0, 24'h123456, 24'h000123},
        {1'b1, 2'd1, 1'b1, 24'h123456, 24'h000C48},
        {1'b1, 2'd2, 1'b0, 24'h123456, 24'h001234},
        {1'b1, 2'd2, 1'b1, 24'h123456, 24'h002C48},
        {1'b1, 2'd3, 1'b0, 24'h123456, 24'h123456},
        {1'b1, 2'd3, 1'b1, 24'h123456, 24'h6A2C48},
        {1'b0, 2'd0, 1'b0, 24'h123456, 24'h560000},
        {1'b0, 2'd1, 1'b0, 24'h123456, 24'h456000},
        {1'b0, 2'd2, 1'b0, 24'h00ABCD, 24'hABCD00},
        {1'b0, 2'd3, 1'b1, 24'h123456, 24'h6A2C48},
        {1'b0, 2'd2, 1'b1, 24'h001234, 24'h00002C}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        tx_strobe = 1'b0, rx_strobe = 1'b0;
    logic        tx_fs_ev = 1'b0, tx_fs_val = 1'b0, rx_fs_ev = 1'b0, rx_fs_val = 1'b0;
    logic [23:0] rx_line = '0;
    logic [23:0] tx_line;
    logic [5:0]  frame_div;
    logic        flag_tde, flag_rdf, flag_tfs, flag_rfs;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sser_link u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_strobe(tx_strobe), .rx_strobe(rx_strobe),
        .tx_fs_ev(tx_fs_ev), .tx_fs_val(tx_fs_val),
        .rx_fs_ev(rx_fs_ev), .rx_fs_val(rx_fs_val),
        .rx_line(rx_line), .tx_line(tx_line), .frame_div(frame_div),
        .flag_tde(flag_tde), .flag_rdf(flag_rdf),
        .flag_tfs(flag_tfs), .flag_rfs(flag_rfs)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%06h expected=0x%06h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [23:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_data(output logic [23:0] d);
        @(negedge clk);
        reg_addr = 2'd3; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tx_pulse();
        @(negedge clk); tx_strobe = 1'b1;
        @(negedge clk); tx_strobe = 1'b0;
    endtask

    task automatic rx_pulse(input logic [23:0] w);
        @(negedge clk); rx_strobe = 1'b1; rx_line = w;
        @(negedge clk); rx_strobe = 1'b0;
    endtask

    task automatic tx_fs(input logic v);
        @(negedge clk); tx_fs_ev = 1'b1; tx_fs_val = v;
        @(negedge clk); tx_fs_ev = 1'b0;
    endtask

    task automatic rx_fs(input logic v);
        @(negedge clk); rx_fs_ev = 1'b1; rx_fs_val = v;
        @(negedge clk); rx_fs_ev = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd2, v); check("R1 status", v, 24'h000001);
        check("R1 tx_line", tx_line, 24'h0);
        peek(2'd0, v); check("R1 ctlA", v, 24'h0);
        peek(2'd1, v); check("R1 ctlB", v, 24'h0);

        // R5 R6 strobes before any frame sync give zero
        wr(2'd1, 24'h000038);
        wr(2'd3, 24'h123456);
        check("R7 tde cleared by data write", {23'd0, flag_tde}, 24'd1 ^ 24'd1);
        tx_pulse();
        check("R5 waiting tx drives 0", tx_line, 24'h0);
        check("R7 tde set by strobe", {23'd0, flag_tde}, 24'd1);
        rx_pulse(24'h123456);
        check("R8 rdf set by strobe", {23'd0, flag_rdf}, 24'd1);
        rd_data(v);
        check("R6 waiting rx stores 0", v, 24'h0);
        check("R8 rdf cleared by read", {23'd0, flag_rdf}, 24'd0);

        // R9 network frame syncs release both directions
        tx_fs(1'b1);
        rx_fs(1'b1);
        peek(2'd2, v); check("R9 frame flags set", v & 24'hC, 24'h00000C);

        // R2 R3 R4 table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [51:0] e;
            e = VEC[i];
            wr(2'd0, {22'd0, e[50:49]});
            wr(2'd1, 24'h000038 | {22'd0, e[48], 1'b0});
            if (e[51]) begin
                wr(2'd3, e[47:24]);
                tx_pulse();
                check(e[48] ? "R4 tx reversed" : "R2 tx aligned", tx_line, e[23:0]);
            end else begin
                rx_pulse(e[47:24]);
                rd_data(v);
                check(e[48] ? "R4 rx reversed" : "R3 rx aligned", v, e[23:0]);
            end
        end

        // R7 dummy status write clears tde
        check("R7 tde set before dummy", {23'd0, flag_tde}, 24'd1);
        wr(2'd2, 24'h0);
        check("R7 dummy write clears tde", {23'd0, flag_tde}, 24'd0);

        // R9 network value 0 clears flag
        tx_fs(1'b0);
        check("R9 net fs 0 clears tfs", {23'd0, flag_tfs}, 24'd0);
        rx_fs(1'b0);
        check("R9 net fs 0 clears rfs", {23'd0, flag_rfs}, 24'd0);

        // R10 normal mode: value 0 still sets flag
        wr(2'd0, 24'h000003);
        wr(2'd1, 24'h000030);
        tx_fs(1'b0);
        check("R10 normal fs sets tfs", {23'd0, flag_tfs}, 24'd1);

        // R5 R10 re-enable waits; normal-mode sync does not release
        wr(2'd1, 24'h000000);
        wr(2'd1, 24'h000030);
        tx_fs(1'b1);
        wr(2'd3, 24'h00ABCD);
        tx_pulse();
        check("R10 normal sync keeps wait", tx_line, 24'h0);
        rx_pulse(24'h654321);
        rd_data(v);
        check("R6 re-enabled rx waits", v, 24'h0);

        // R9 network sync then releases; R5 with TE low drives 0
        wr(2'd1, 24'h000038);
        tx_fs(1'b1);
        tx_pulse();
        check("R9 released tx", tx_line, 24'h00ABCD);
        wr(2'd1, 24'h000028);
        tx_pulse();
        check("R5 tx disabled drives 0", tx_line, 24'h0);

        // R11 R12 divider and readback
        wr(2'd0, 24'h000014);
        check("R11 divider 5+1", {18'd0, frame_div}, 24'd6);
        wr(2'd0, 24'h00007F);
        check("R11 divider 31+1", {18'd0, frame_div}, 24'd32);
        peek(2'd0, v); check("R12 ctlA readback", v, 24'h00007F);
        wr(2'd1, 24'h0000C5);
        peek(2'd1, v); check("R12 ctlB readback", v, 24'h0000C5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule